// File: doc/BRIEF.md
# Five-Stage Pipeline Branch-Flush Controller

This block is the sequencing control for a five-stage instruction pipeline. The stages, in order, are fetch, decode, access, read and execute. Each stage holds a valid bit and an instruction tag. On every cycle that is not stalled, each entry moves one stage forward. The block produces the fetch address and takes the instruction tag that comes back for that address. The arithmetic datapath and the memories sit outside it.

A taken branch is resolved while the branch occupies the read stage. In that same cycle the fetch address switches to the branch target. The three younger entries in fetch, decode and access are turned into bubbles. Each taken branch therefore costs a fixed three cycles. The bubbles move down the pipe like normal entries and leave execute without effect. A counter of bubbles leaving execute makes that penalty visible.

A hardware repeat unit handles loops by steering fetch from the last loop address back to the first one. This redirection happens at fetch time, so it causes no flush and no lost cycles.

Top module: `pipe_flush_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it, all five stage valid bits are 0, `fetch_addr_o` equals `RESET_ADDR` (default 0) and `bubble_cnt_o` is 0.
- R2: On each clock edge without a stall or flush, the following happen together:
  - The fetch stage (index 0) captures `fetch_tag_i` with valid set.
  - Stage i+1 takes the valid bit and tag of stage i.
  - The fetch address advances by one.
- R3: With `stall_i` high and no flush, an edge leaves all of the following unchanged: stage valid bits, stage tags, the fetch address and the bubble count.
- R4: A flush happens when `br_taken_i` is high while the read stage (index 3) is valid. In that same cycle `fetch_addr_o` equals `br_target_i`. At the next edge:
  - Decode, access and read (indices 1 to 3) become invalid.
  - Execute (index 4) receives the branch.
  - Fetch receives the target's tag with valid set.
- R5: A taken branch costs exactly three cycles. After the flush edge, the target tag reaches the read stage three edges later, and exactly three bubbles leave execute as a result of the flush.
- R6: `br_taken_i` has no effect while the read stage is invalid: the fetch address is not redirected and no stage is cleared.
- R7: A flush that coincides with `stall_i` high takes priority: the pipeline advances and flushes as in R4.
- R8: Loading the repeat unit with first address F, last address L and count N makes fetch return from L to F N times. After that, fetch continues at L+1. The body is fetched N+1 times in total and no bubble is added.
- R9: `bubble_cnt_o` increments by one on each advancing edge on which the execute stage is invalid, and at no other time.
- R10: When a flush and a repeat return fall on the same cycle, the branch target is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Freezes pipeline, fetch address and counter |
| fetch_tag_i | input | TAG_W | Tag of the instruction at `fetch_addr_o` |
| fetch_addr_o | output | ADDR_W | Address being fetched this cycle |
| br_taken_i | input | 1 | The entry in the read stage is a taken branch |
| br_target_i | input | ADDR_W | Branch target address |
| rpt_load_i | input | 1 | Loads the repeat unit |
| rpt_first_i | input | ADDR_W | First address of the repeated block |
| rpt_last_i | input | ADDR_W | Last address of the repeated block |
| rpt_count_i | input | RPT_W | Number of extra passes |
| stage_valid_o | output | 5 | Valid bit per stage, bit 0 = fetch, bit 4 = execute |
| stage_tag_o | output | 5*TAG_W | Tag per stage, stage i in bits [i*TAG_W +: TAG_W] |
| bubble_cnt_o | output | CNT_W | Number of bubbles retired from execute |

## Verification
The bench places a branch in the read stage and follows the target to count the lost cycles. A design that clears one stage too many or too few would show four or two bubbles instead of three. A design that redirected fetch one cycle late would also show four. A taken flag raised while the read stage is empty must leave fetch on its linear path; a design that ignored the valid qualifier would jump. A branch combined with a stall must still advance, so a design that honoured the stall first would keep the branch stuck in read. Repeat loops are run to completion to catch off-by-one pass counts. They are also raced against a branch, so a design that let the loop win would fetch the loop's first address.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
   localparam int unsigned NSTG    = 5;
   localparam int unsigned STG_FET = 0;
   localparam int unsigned STG_DEC = 1;
   localparam int unsigned STG_ACC = 2;
   localparam int unsigned STG_RD  = 3;
   localparam int unsigned STG_EX  = 4;
   // stages strictly younger than the resolving stage are killed
   localparam int unsigned KILL_DEPTH = STG_RD;

   typedef enum logic [1:0] {
      NXT_SEQ    = 2'd0,
      NXT_LOOP   = 2'd1,
      NXT_BRANCH = 2'd2,
      NXT_HOLD   = 2'd3
   } nxt_src_e;
endpackage

// File: rtl/pfc_stage_chain.sv
module pfc_stage_chain
   import pfc_pkg::*;
#(
   parameter int unsigned TAG_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    adv,
   input  logic                    flush,
   input  logic [TAG_W-1:0]        in_tag,
   output logic [NSTG-1:0]         valid_o,
   output logic [NSTG*TAG_W-1:0]   tag_o
);
   logic [NSTG-1:0]  vld_q;
   logic [TAG_W-1:0] tag_q [NSTG];

   generate
      for (genvar s = 0; s < NSTG; s++) begin : g_stg
         if (s == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  vld_q[s] <= 1'b0;
                  tag_q[s] <= '0;
               end else if (adv) begin
                  vld_q[s] <= 1'b1;
                  tag_q[s] <= in_tag;
               end
            end
         end else if (s <= KILL_DEPTH) begin : g_killable
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  vld_q[s] <= 1'b0;
                  tag_q[s] <= '0;
               end else if (adv) begin
                  vld_q[s] <= vld_q[s-1] & ~flush;
                  tag_q[s] <= tag_q[s-1];
               end
            end
         end else begin : g_older
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  vld_q[s] <= 1'b0;
                  tag_q[s] <= '0;
               end else if (adv) begin
                  vld_q[s] <= vld_q[s-1];
                  tag_q[s] <= tag_q[s-1];
               end
            end
         end
         assign tag_o[s*TAG_W +: TAG_W] = tag_q[s];
      end
   endgenerate

   assign valid_o = vld_q;
endmodule

// File: rtl/pfc_loop_unit.sv
module pfc_loop_unit #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned RPT_W   = 8,
   parameter bit          LOOP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] first_i,
   input  logic [ADDR_W-1:0] last_i,
   input  logic [RPT_W-1:0]  count_i,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              adv,
   input  logic              flush,
   output logic              take_o,
   output logic [ADDR_W-1:0] first_o
);
   generate
      if (LOOP_EN) begin : g_loop
         logic              act_q;
         logic [RPT_W-1:0]  cnt_q;
         logic [ADDR_W-1:0] first_q;
         logic [ADDR_W-1:0] last_q;
         logic              at_end;

         assign at_end = act_q && (fetch_addr == last_q);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_q   <= 1'b0;
               cnt_q   <= '0;
               first_q <= '0;
               last_q  <= '0;
            end else if (load) begin
               act_q   <= 1'b1;
               cnt_q   <= count_i;
               first_q <= first_i;
               last_q  <= last_i;
            end else if (adv && !flush && at_end) begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end else begin
                  act_q <= 1'b0;
               end
            end
         end

         assign take_o  = at_end && (cnt_q != '0) && !flush;
         assign first_o = first_q;
      end else begin : g_noloop
         assign take_o  = 1'b0;
         assign first_o = '0;
      end
   endgenerate
endmodule

// File: rtl/pfc_addr_gen.sv
module pfc_addr_gen
   import pfc_pkg::*;
#(
   parameter int unsigned        ADDR_W     = 16,
   parameter logic [ADDR_W-1:0]  RESET_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              flush,
   input  logic [ADDR_W-1:0] target_i,
   input  logic              loop_take,
   input  logic [ADDR_W-1:0] loop_first,
   output logic [ADDR_W-1:0] fetch_addr_o
);
   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] pc_d;
   nxt_src_e          src;

   assign fetch_addr_o = flush ? target_i : pc_q;

   always_comb begin
      if (!adv)           src = NXT_HOLD;
      else if (flush)     src = NXT_BRANCH;
      else if (loop_take) src = NXT_LOOP;
      else                src = NXT_SEQ;
   end

   always_comb begin
      unique case (src)
         NXT_HOLD:   pc_d = pc_q;
         NXT_LOOP:   pc_d = loop_first;
         NXT_BRANCH: pc_d = target_i + 1'b1;
         default:    pc_d = pc_q + 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= RESET_ADDR;
      else        pc_q <= pc_d;
   end
endmodule

// File: rtl/pfc_bubble_ctr.sv
module pfc_bubble_ctr #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             ex_valid,
   output logic [CNT_W-1:0] cnt_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_o <= '0;
      else if (adv && !ex_valid) cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/pipe_flush_ctrl.sv
module pipe_flush_ctrl
   import pfc_pkg::*;
#(
   parameter int unsigned        ADDR_W     = 16,
   parameter int unsigned        TAG_W      = 8,
   parameter int unsigned        RPT_W      = 8,
   parameter int unsigned        CNT_W      = 16,
   parameter logic [ADDR_W-1:0]  RESET_ADDR = '0,
   parameter bit                 LOOP_EN    = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  stall_i,
   input  logic [TAG_W-1:0]      fetch_tag_i,
   output logic [ADDR_W-1:0]     fetch_addr_o,
   input  logic                  br_taken_i,
   input  logic [ADDR_W-1:0]     br_target_i,
   input  logic                  rpt_load_i,
   input  logic [ADDR_W-1:0]     rpt_first_i,
   input  logic [ADDR_W-1:0]     rpt_last_i,
   input  logic [RPT_W-1:0]      rpt_count_i,
   output logic [NSTG-1:0]       stage_valid_o,
   output logic [NSTG*TAG_W-1:0] stage_tag_o,
   output logic [CNT_W-1:0]      bubble_cnt_o
);
   generate
      if (ADDR_W < 2)  begin : g_bad_addr $error("ADDR_W must be at least 2"); end
      if (TAG_W < 1)   begin : g_bad_tag  $error("TAG_W must be at least 1"); end
      if (RPT_W < 1)   begin : g_bad_rpt  $error("RPT_W must be at least 1"); end
      if (CNT_W < 2)   begin : g_bad_cnt  $error("CNT_W must be at least 2"); end
   endgenerate

   logic              flush;
   logic              adv;
   logic              loop_take;
   logic [ADDR_W-1:0] loop_first;

   // branch resolves in the read stage; flush wins over stall
   assign flush = br_taken_i & stage_valid_o[STG_RD];
   assign adv   = flush | ~stall_i;

   pfc_loop_unit #(.ADDR_W(ADDR_W), .RPT_W(RPT_W), .LOOP_EN(LOOP_EN)) u_loop (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (rpt_load_i),
      .first_i    (rpt_first_i),
      .last_i     (rpt_last_i),
      .count_i    (rpt_count_i),
      .fetch_addr (fetch_addr_o),
      .adv        (adv),
      .flush      (flush),
      .take_o     (loop_take),
      .first_o    (loop_first)
   );

   pfc_addr_gen #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_addr (
      .clk          (clk),
      .rst_n        (rst_n),
      .adv          (adv),
      .flush        (flush),
      .target_i     (br_target_i),
      .loop_take    (loop_take),
      .loop_first   (loop_first),
      .fetch_addr_o (fetch_addr_o)
   );

   pfc_stage_chain #(.TAG_W(TAG_W)) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .flush   (flush),
      .in_tag  (fetch_tag_i),
      .valid_o (stage_valid_o),
      .tag_o   (stage_tag_o)
   );

   pfc_bubble_ctr #(.CNT_W(CNT_W)) u_bub (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .ex_valid (stage_valid_o[STG_EX]),
      .cnt_o    (bubble_cnt_o)
   );
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned TAG_W  = 8,
   parameter int unsigned CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stall_i,
   input logic              br_taken_i,
   input logic [ADDR_W-1:0] br_target_i,
   input logic [ADDR_W-1:0] fetch_addr_o,
   input logic [4:0]        stage_valid_o,
   input logic [5*TAG_W-1:0] stage_tag_o,
   input logic [CNT_W-1:0]  bubble_cnt_o
);
   logic chk_flush;
   logic chk_adv;
   assign chk_flush = br_taken_i && stage_valid_o[3];
   assign chk_adv   = chk_flush || !stall_i;

   a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
      chk_adv |=> (stage_valid_o[4] == $past(stage_valid_o[3])) &&
                  (stage_tag_o[4*TAG_W +: TAG_W] == $past(stage_tag_o[3*TAG_W +: TAG_W])));

   a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_i && !chk_flush) |=> $stable(stage_valid_o) && $stable(stage_tag_o) &&
                                  $stable(bubble_cnt_o));

   a_r4_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      chk_flush |-> fetch_addr_o == br_target_i);

   a_r4_kill: assert property (@(posedge clk) disable iff (!rst_n)
      chk_flush |=> (stage_valid_o[3:1] == 3'b000) && stage_valid_o[4]);

   a_r6_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (br_taken_i && !stage_valid_o[3] && !stall_i) |=>
         stage_valid_o[0] && (stage_valid_o[3] == $past(stage_valid_o[2])));

   a_r7_flush_over_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_flush && stall_i) |=> stage_valid_o[4] && (stage_valid_o[3:1] == 3'b000));

   a_r9_bubble_count: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_adv && !stage_valid_o[4]) |=> bubble_cnt_o == $past(bubble_cnt_o) + 1'b1);
endmodule

bind pipe_flush_ctrl pfc_checker #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .stall_i       (stall_i),
   .br_taken_i    (br_taken_i),
   .br_target_i   (br_target_i),
   .fetch_addr_o  (fetch_addr_o),
   .stage_valid_o (stage_valid_o),
   .stage_tag_o   (stage_tag_o),
   .bubble_cnt_o  (bubble_cnt_o)
);

// File: tb/tb_pipe_flush_ctrl.sv
`timescale 1ns/1ps
module tb_pipe_flush_ctrl;
   localparam int unsigned AW = 16;
   localparam int unsigned TW = 8;
   localparam int unsigned RW = 8;
   localparam int unsigned CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stall = 1'b0;
   logic [TW-1:0] ftag;
   logic [AW-1:0] faddr;
   logic          br = 1'b0;
   logic [AW-1:0] tgt = '0;
   logic          rload = 1'b0;
   logic [AW-1:0] rfirst = '0;
   logic [AW-1:0] rlast = '0;
   logic [RW-1:0] rcnt = '0;
   logic [4:0]    vld;
   logic [5*TW-1:0] tags;
   logic [CW-1:0] bub;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   // instruction memory model: tag is the low byte of the address
   assign ftag = faddr[TW-1:0];

   pipe_flush_ctrl #(.ADDR_W(AW), .TAG_W(TW), .RPT_W(RW), .CNT_W(CW)) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .stall_i       (stall),
      .fetch_tag_i   (ftag),
      .fetch_addr_o  (faddr),
      .br_taken_i    (br),
      .br_target_i   (tgt),
      .rpt_load_i    (rload),
      .rpt_first_i   (rfirst),
      .rpt_last_i    (rlast),
      .rpt_count_i   (rcnt),
      .stage_valid_o (vld),
      .stage_tag_o   (tags),
      .bubble_cnt_o  (bub)
   );

   function automatic logic [TW-1:0] tg(input int s);
      return tags[s*TW +: TW];
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; stall = 1'b0; br = 1'b0; rload = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      chk(vld == 5'b0, "R1 valid", 32'(vld), 0);
      chk(faddr == 16'h0, "R1 addr", 32'(faddr), 0);
      chk(bub == '0, "R1 bubbles", 32'(bub), 0);
   endtask

   task automatic t_stream();
      do_reset();
      for (int n = 1; n <= 8; n++) begin
         step();
         chk(vld[0] && tg(0) == TW'(n - 1), "R2 fetch tag", 32'(tg(0)), 32'(n - 1));
         chk(faddr == AW'(n), "R2 addr", 32'(faddr), 32'(n));
      end
      for (int s = 0; s < 5; s++)
         chk(vld[s] && tg(s) == TW'(7 - s), "R2 stage tag", 32'(tg(s)), 32'(7 - s));
      chk(bub == CW'(5), "R9 startup bubbles", 32'(bub), 5);
   endtask

   task automatic t_stall();
      logic [4:0]    v0;
      logic [5*TW-1:0] t0;
      logic [AW-1:0] a0;
      logic [CW-1:0] b0;
      v0 = vld; t0 = tags; a0 = faddr; b0 = bub;
      stall = 1'b1;
      repeat (3) begin
         step();
         chk(vld == v0 && tags == t0, "R3 stages frozen", 32'(tg(0)), 32'(t0[TW-1:0]));
         chk(faddr == a0, "R3 addr frozen", 32'(faddr), 32'(a0));
         chk(bub == b0, "R3 count frozen", 32'(bub), 32'(b0));
      end
      stall = 1'b0;
      step();
      chk(tg(0) == a0[TW-1:0], "R2 resume", 32'(tg(0)), 32'(a0[TW-1:0]));
   endtask

   task automatic run_until_read(input logic [TW-1:0] t);
      for (int i = 0; i < 40; i++) begin
         if (vld[3] && tg(3) == t) break;
         step();
      end
   endtask

   task automatic t_branch();
      logic [CW-1:0] b0;
      do_reset();
      run_until_read(8'h05);
      br = 1'b1; tgt = 16'h0040;
      #1;
      chk(faddr == 16'h0040, "R4 same-cycle redirect", 32'(faddr), 32'h40);
      b0 = bub;
      step();
      br = 1'b0;
      chk(vld[3:1] == 3'b000, "R4 younger killed", 32'(vld), 0);
      chk(vld[4] && tg(4) == 8'h05, "R4 branch in execute", 32'(tg(4)), 5);
      chk(vld[0] && tg(0) == 8'h40, "R4 target fetched", 32'(tg(0)), 32'h40);
      repeat (3) step();
      chk(vld[3] && tg(3) == 8'h40, "R5 target in read", 32'(tg(3)), 32'h40);
      step();
      chk(vld[4] && tg(4) == 8'h40, "R5 target in execute", 32'(tg(4)), 32'h40);
      chk(bub == b0 + CW'(3), "R5 three bubbles", 32'(bub - b0), 3);
      step();
      chk(bub == b0 + CW'(3), "R9 no extra bubble", 32'(bub - b0), 3);
   endtask

   task automatic t_ignore();
      do_reset();
      br = 1'b1; tgt = 16'h0050;
      #1;
      chk(faddr == 16'h0000, "R6 no redirect", 32'(faddr), 0);
      step();
      br = 1'b0;
      chk(vld[0] && tg(0) == 8'h00, "R6 fetch unaffected", 32'(tg(0)), 0);
      chk(faddr == 16'h0001, "R6 linear addr", 32'(faddr), 1);
   endtask

   task automatic t_br_stall();
      do_reset();
      run_until_read(8'h05);
      stall = 1'b1; br = 1'b1; tgt = 16'h0060;
      step();
      br = 1'b0;
      chk(vld[4] && tg(4) == 8'h05, "R7 branch advanced", 32'(tg(4)), 5);
      chk(vld[3:1] == 3'b000, "R7 flushed under stall", 32'(vld), 0);
      chk(tg(0) == 8'h60, "R7 target fetched", 32'(tg(0)), 32'h60);
      step();
      chk(tg(0) == 8'h60 && faddr == 16'h0061, "R3 stall after flush", 32'(faddr), 32'h61);
      stall = 1'b0;
   endtask

   task automatic t_loop();
      logic [TW-1:0] exp_seq [12] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd2,
                                      8'd3, 8'd4, 8'd2, 8'd3, 8'd4, 8'd5};
      do_reset();
      rload = 1'b1; rfirst = 16'd2; rlast = 16'd4; rcnt = 8'd2;
      for (int n = 0; n < 12; n++) begin
         step();
         rload = 1'b0;
         chk(tg(0) == exp_seq[n], "R8 loop fetch order", 32'(tg(0)), 32'(exp_seq[n]));
      end
      chk(bub == CW'(5), "R8 no loop penalty", 32'(bub), 5);
   endtask

   task automatic t_loop_branch();
      do_reset();
      rload = 1'b1; rfirst = 16'd2; rlast = 16'd4; rcnt = 8'd3;
      step();
      rload = 1'b0;
      repeat (3) step();
      br = 1'b1; tgt = 16'h0030;
      #1;
      chk(faddr == 16'h0030, "R10 branch beats loop", 32'(faddr), 32'h30);
      step();
      br = 1'b0;
      chk(tg(0) == 8'h30, "R10 target fetched", 32'(tg(0)), 32'h30);
      step();
      chk(tg(0) == 8'h31, "R10 linear after target", 32'(tg(0)), 32'h31);
   endtask

   initial begin
      t_reset();
      t_stream();
      t_stall();
      t_branch();
      t_ignore();
      t_br_stall();
      t_loop();
      t_loop_branch();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule